// File: doc/BRIEF.md
# Programmable Lookup-Table Logic Section

This block is one section of a programmable logic unit. Eight input lines form an address into a 256-word by 8-bit truth-table memory. Each bit of the addressed word drives one output, so every output can be its own Boolean function of the eight inputs: an AND, OR, parity, inhibit, majority or count threshold, or any mix of these. The outputs are registered, so each output shows the table entry for the inputs sampled at the previous clock edge.

A separate command controller fills the table through a synchronous write port. It reads the table back through an asynchronous read port. A strobe records the live input pattern in a pattern register, which is kept for later readback so the trigger can be reconstructed. The pattern register is governed by a two-state machine:

- `CAP_EMPTY`: the register is clear.
- `CAP_HELD`: a pattern has been captured.

The machine has two transitions:

- *capture* goes from `CAP_EMPTY` to `CAP_HELD`. It fires on a strobe with no clear.
- *release* goes from `CAP_HELD` to `CAP_EMPTY`. It fires on any clear.

In every other case the state holds. A clear can come from a front-panel line or from the controller's clear command. The indicator `strobe_seen` is lit while the machine is in `CAP_HELD`.

Top module: `lutsec_top`

## Requirements
- R1: While `rst_n` is low, `pattern` is 0x00, `strobe_seen` is 0 and `func_out` is 0x00. The table contents are not reset.
- R2: At each rising clock edge, `func_out` loads the table word addressed by `in_lines`. Bit k of `func_out` is bit k of that word, which gives one cycle of latency.
- R3: A write with `wr_en` high stores `wr_data` at `wr_addr` at the clock edge. Writing one address leaves every other address unchanged.
- R4: `rd_data` shows the word at `rd_addr` combinationally, and it reflects a write from the cycle after that write.
- R5: In `CAP_EMPTY`, a strobe with no clear copies `in_lines` into `pattern` at the edge and moves the machine to `CAP_HELD`. `strobe_seen` then reads 1.
- R6: In `CAP_HELD`, further strobes are ignored. `pattern` keeps the first captured value until a clear.
- R7: `clear_ext` or `clear_cmd` moves the machine to `CAP_EMPTY` at the edge, sets `pattern` to 0x00 and sets `strobe_seen` to 0.
- R8: When a strobe and a clear arrive in the same cycle, the clear wins and the machine ends in `CAP_EMPTY` with `pattern` at 0x00.
- R9: The function outputs keep following `in_lines` through the table in both capture states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_lines | input | 8 | Live input pattern and table address |
| strobe | input | 1 | Capture request for the pattern register |
| clear_ext | input | 1 | Front-panel clear of the pattern register |
| clear_cmd | input | 1 | Controller clear of the pattern register |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | 8 | Table write address |
| wr_data | input | 8 | Table write data |
| rd_addr | input | 8 | Table readback address |
| rd_data | output | 8 | Table word at `rd_addr` |
| func_out | output | 8 | Registered function outputs |
| pattern | output | 8 | Captured input pattern |
| strobe_seen | output | 1 | Capture-state indicator |

## Verification
The assertions assume that `strobe`, `clear_ext`, `clear_cmd` and the write port are synchronous levels, free of X after reset, that are sampled once per edge. They also assume that a table word counts only once it has been written, since the table has no reset value. The stimulus changes every input half a cycle away from the sampling edge. It loads all 256 words before it compares any function output, and it holds each strobe or clear for exactly one cycle, except in the deliberate case where both arrive together.

// File: rtl/lutsec_pkg.sv
package lutsec_pkg;

    // Capture machine for the strobe-latched pattern register
    typedef enum logic [0:0] {
        CAP_EMPTY = 1'b0,
        CAP_HELD  = 1'b1
    } cap_state_t;

endpackage

// File: rtl/lutsec_mem.sv
module lutsec_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] fn_addr,
    output logic [DATA_W-1:0] fn_word,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] table_q [DEPTH];

    // Synchronous write, contents not reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            table_q[wr_addr] <= wr_data;
        end
    end

    // Two asynchronous read ports: live function path and readback
    always_comb begin
        fn_word = table_q[fn_addr];
        rb_word = table_q[rb_addr];
    end

endmodule

// File: rtl/lutsec_capture.sv
module lutsec_capture
    import lutsec_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_lines,
    input  logic         strobe,
    input  logic         clr,
    output logic [W-1:0] pattern,
    output logic         held
);
    cap_state_t state_q;
    cap_state_t state_d;

    // Next-state logic: capture and release transitions, clear has priority
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_EMPTY: begin
                if (strobe && !clr) begin
                    state_d = CAP_HELD;
                end
            end
            CAP_HELD: begin
                if (clr) begin
                    state_d = CAP_EMPTY;
                end
            end
            default: state_d = CAP_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Pattern register loads only on the capture transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pattern <= '0;
        end else if (clr) begin
            pattern <= '0;
        end else if (state_q == CAP_EMPTY && strobe) begin
            pattern <= in_lines;
        end
    end

    // Outputs decoded from state
    always_comb begin
        held = (state_q == CAP_HELD);
    end

endmodule

// File: rtl/lutsec_outreg.sv
module lutsec_outreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] word_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_in;
        end
    end

endmodule

// File: rtl/lutsec_top.sv
module lutsec_top #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  in_lines,
    input  logic             strobe,
    input  logic             clear_ext,
    input  logic             clear_cmd,
    input  logic             wr_en,
    input  logic [IN_W-1:0]  wr_addr,
    input  logic [OUT_W-1:0] wr_data,
    input  logic [IN_W-1:0]  rd_addr,
    output logic [OUT_W-1:0] rd_data,
    output logic [OUT_W-1:0] func_out,
    output logic [IN_W-1:0]  pattern,
    output logic             strobe_seen
);
    logic             clr_any;
    logic [OUT_W-1:0] lut_word;

    assign clr_any = clear_ext | clear_cmd;

    lutsec_mem #(
        .ADDR_W (IN_W),
        .DATA_W (OUT_W)
    ) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .fn_addr (in_lines),
        .fn_word (lut_word),
        .rb_addr (rd_addr),
        .rb_word (rd_data)
    );

    lutsec_outreg #(
        .W (OUT_W)
    ) u_outreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_in (lut_word),
        .word_q  (func_out)
    );

    lutsec_capture #(
        .W (IN_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_lines (in_lines),
        .strobe   (strobe),
        .clr      (clr_any),
        .pattern  (pattern),
        .held     (strobe_seen)
    );

endmodule

// File: rtl/lutsec_checker.sv
module lutsec_checker #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IN_W-1:0]  in_lines,
    input logic             strobe,
    input logic             clr_any,
    input logic             wr_en,
    input logic [IN_W-1:0]  wr_addr,
    input logic [OUT_W-1:0] wr_data,
    input logic [IN_W-1:0]  rd_addr,
    input logic [OUT_W-1:0] rd_data,
    input logic [IN_W-1:0]  pattern,
    input logic             strobe_seen
);
    // R1 / R7: the register is zero whenever the machine is empty
    assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_seen |-> pattern == '0);

    // R5: capture from the empty state
    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_seen && strobe && !clr_any) |=> (strobe_seen && pattern == $past(in_lines)));

    // R6: the held pattern is frozen until a clear
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_seen && !clr_any) |=> (strobe_seen && $stable(pattern)));

    // R7 / R8: a clear always empties, even with a strobe present
    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_any |=> (!strobe_seen && pattern == '0));

    // R4: readback of a just-written address returns the written data
    assert_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_addr != $past(wr_addr)) || (rd_data == $past(wr_data))));

endmodule

bind lutsec_top lutsec_checker #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_lines    (in_lines),
    .strobe      (strobe),
    .clr_any     (clr_any),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .pattern     (pattern),
    .strobe_seen (strobe_seen)
);

// File: tb/lutsec_top_bench.sv
`timescale 1ns/1ps
module lutsec_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_lines = '0;
    logic       strobe = 1'b0;
    logic       clear_ext = 1'b0;
    logic       clear_cmd = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] func_out;
    logic [7:0] pattern;
    logic       strobe_seen;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lutsec_top u_lutsec_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_lines    (in_lines),
        .strobe      (strobe),
        .clear_ext   (clear_ext),
        .clear_cmd   (clear_cmd),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .func_out    (func_out),
        .pattern     (pattern),
        .strobe_seen (strobe_seen)
    );

    // Functions the table is programmed with: all, any, parity, three-or-more,
    // inhibit, and three bits of a cross XOR
    function automatic logic [7:0] model(input logic [7:0] a);
        logic [7:0] w;
        w[0]   = &a;
        w[1]   = |a;
        w[2]   = ^a;
        w[3]   = ($countones(a) >= 3);
        w[4]   = a[0] & ~a[1];
        w[7:5] = a[7:5] ^ a[2:0];
        return w;
    endfunction

    localparam logic [7:0] VEC [12] = '{
        8'h00, 8'hFF, 8'h01, 8'h02, 8'h07, 8'h80,
        8'hA5, 8'h5A, 8'h3C, 8'hC3, 8'h11, 8'hFE
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 pattern", pattern, 8'h00);
        check("R1 strobe_seen", {7'd0, strobe_seen}, 8'h00);
        check("R1 func_out", func_out, 8'h00);
        rst_n = 1'b1;

        // R3: load the full table
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_addr = 8'(a);
            wr_data = model(8'(a));
        end
        @(negedge clk);
        wr_en = 1'b0;

        // R4: combinational readback
        for (int i = 0; i < 4; i++) begin
            rd_addr = VEC[i * 3];
            #1;
            check("R4 readback", rd_data, model(VEC[i * 3]));
        end

        // R2: vector table through the function path
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            in_lines = VEC[i];
            @(negedge clk);
            check("R2 func_out", func_out, model(VEC[i]));
        end

        // R5: capture
        @(negedge clk);
        in_lines = 8'hA5;
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        check("R5 pattern", pattern, 8'hA5);
        check("R5 strobe_seen", {7'd0, strobe_seen}, 8'h01);

        // R6: second strobe ignored; R9: outputs still follow inputs
        in_lines = 8'h3C;
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        check("R6 pattern held", pattern, 8'hA5);
        check("R9 func_out while held", func_out, model(8'h3C));

        // R7: front-panel clear
        clear_ext = 1'b1;
        @(negedge clk);
        clear_ext = 1'b0;
        check("R7 ext pattern", pattern, 8'h00);
        check("R7 ext strobe_seen", {7'd0, strobe_seen}, 8'h00);

        // R5 again, then R7 via command clear
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        check("R5 recapture", pattern, 8'h3C);
        clear_cmd = 1'b1;
        @(negedge clk);
        clear_cmd = 1'b0;
        check("R7 cmd pattern", pattern, 8'h00);
        check("R7 cmd strobe_seen", {7'd0, strobe_seen}, 8'h00);

        // R8: strobe and clear together
        in_lines = 8'hFF;
        strobe = 1'b1;
        clear_ext = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        clear_ext = 1'b0;
        check("R8 pattern", pattern, 8'h00);
        check("R8 strobe_seen", {7'd0, strobe_seen}, 8'h00);

        // R3: single-word rewrite, neighbour untouched
        wr_en = 1'b1;
        wr_addr = 8'h81;
        wr_data = 8'h5A;
        @(negedge clk);
        wr_en = 1'b0;
        rd_addr = 8'h81;
        #1;
        check("R4 readback after write", rd_data, 8'h5A);
        rd_addr = 8'h80;
        #1;
        check("R3 neighbour unchanged", rd_data, model(8'h80));
        in_lines = 8'h81;
        @(negedge clk);
        check("R3 func_out new word", func_out, 8'h5A);
        in_lines = 8'h80;
        @(negedge clk);
        check("R3 func_out neighbour", func_out, model(8'h80));

        finish_run();
    end

endmodule